// File: doc/BRIEF.md
# Mixed-Width Byte FIFO

This block puts two byte queues behind a single 16-bit host data register. One queue carries host-written bytes out to the card-side logic. The other carries card-delivered bytes in to the host. The host may touch the register at byte width or at word width, and it may switch between the two from one access to the next. A word access stands for two consecutive queue bytes, and the more significant half is always the earlier byte in the queue.

The card side moves single bytes with a valid/ready handshake, at most one per clock in each direction. The host sees byte counts plus full and empty indications for both queues. Three one-cycle pulses report rejected accesses: a write with too little room, a read with too few bytes, and a byte access at the odd register address. A rejected access changes no queue.

Top module: `wbf_top`

## Requirements
- R1: After reset both queues are empty, both levels are 0, `tx_valid` is 0, `rx_ready` is 1, all three flags are 0 and `host_rdata` is 0.
- R2: An accepted word write (`host_word`=1) appends `host_wdata[15:8]` and then `host_wdata[7:0]` to the outbound queue. An accepted byte write (`host_word`=0, `host_addr0`=0) appends `host_wdata[7:0]`. Writing word 0x0123, byte 0x45, word 0x6789 and byte 0xAB yields outbound bytes 01,23,45,67,89,AB.
- R3: An accepted word read pops two inbound bytes and returns the first in `host_rdata[15:8]` and the second in `host_rdata[7:0]`. An accepted byte read pops one byte and returns {8'h00, byte}. The value appears on the clock after the read strobe. With inbound bytes 01,23,45,67,89,AB, the reads byte, word, byte, word return 0x0001, 0x2345, 0x0067 and 0x89AB.
- R4: Word and byte accesses may be interleaved in any order, and byte order is preserved across them in both queues.
- R5: `tx_valid` is 1 exactly when the outbound queue holds a byte, and `tx_data` is then its oldest byte. One byte is removed on each clock where `tx_valid` and `tx_ready` are both 1.
- R6: `rx_ready` is 1 exactly when the inbound queue is not full. On each clock where `rx_valid` and `rx_ready` are both 1, `rx_data` is appended.
- R7: Each level equals the bytes stored in its queue. Within a cycle it changes by pushes minus pops. Full means the level equals DEPTH, and empty means the level is 0.
- R8: A write needing more free bytes than the outbound queue had at the start of the cycle pushes nothing. `ovf_flag` is then 1 for the following cycle.
- R9: A read needing more bytes than the inbound queue held at the start of the cycle pops nothing. `host_rdata` becomes 0 and `unf_flag` is 1 for the following cycle.
- R10: A byte access with `host_addr0`=1 is ignored. No push or pop occurs, `host_rdata` keeps its value, and `acc_err` is 1 for the following cycle. Word accesses do not look at `host_addr0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr0 | input | 1 | Low address bit of the register access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| tx_valid | output | 1 | Outbound byte available |
| tx_ready | input | 1 | Card side takes the outbound byte |
| tx_data | output | 8 | Oldest outbound byte |
| rx_valid | input | 1 | Card side offers an inbound byte |
| rx_ready | output | 1 | Inbound queue can accept |
| rx_data | input | 8 | Inbound byte |
| tx_full | output | 1 | Outbound queue full |
| tx_empty | output | 1 | Outbound queue empty |
| tx_level | output | $clog2(DEPTH+1) | Outbound byte count |
| rx_full | output | 1 | Inbound queue full |
| rx_empty | output | 1 | Inbound queue empty |
| rx_level | output | $clog2(DEPTH+1) | Inbound byte count |
| ovf_flag | output | 1 | Write rejected for lack of room (pulse) |
| unf_flag | output | 1 | Read rejected for lack of data (pulse) |
| acc_err | output | 1 | Odd-address byte access ignored (pulse) |

## Verification
A corrupted pointer or count shows up at once in the level outputs. It also shows up within a single card-side pop or host read as a wrong, repeated or skipped byte on `tx_data` or `host_rdata`. A byte-swap fault in the word path appears on the first word access after it. A wrong free-space test shows on the clock after a write into a nearly full queue, either as a missing `ovf_flag` or as a level that grows past DEPTH. Random traffic that swings both queues between empty and full, with its expected bytes kept in a bench model, reaches each of these states many times.

// File: rtl/wbf_pkg.sv
package wbf_pkg;
    typedef logic [7:0] byte_t;
    typedef logic [1:0] bcnt_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_BYTE = 2'd1,
        ACC_WORD = 2'd2,
        ACC_BAD  = 2'd3
    } acc_e;
endpackage

// File: rtl/wbf_byte_queue.sv
module wbf_byte_queue
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bcnt_t         push_cnt,
    input  byte_t         push_b0,
    input  byte_t         push_b1,
    input  bcnt_t         pop_cnt,
    output byte_t         head0,
    output byte_t         head1,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        byte_t [DEPTH-1:0] mem;
        logic [PW-1:0]     wp;
        logic [PW-1:0]     rp;
        logic [LW-1:0]     cnt;
    } q_t;

    q_t d, q;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push_cnt != 2'd0) d.mem[q.wp] = push_b0;
        if (push_cnt == 2'd2) d.mem[inc(q.wp)] = push_b1;
        case (push_cnt)
            2'd1:    d.wp = inc(q.wp);
            2'd2:    d.wp = inc(inc(q.wp));
            default: d.wp = q.wp;
        endcase
        case (pop_cnt)
            2'd1:    d.rp = inc(q.rp);
            2'd2:    d.rp = inc(inc(q.rp));
            default: d.rp = q.rp;
        endcase
        d.cnt = q.cnt + LW'(push_cnt) - LW'(pop_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head0 = q.mem[q.rp];
    assign head1 = q.mem[inc(q.rp)];
    assign level = q.cnt;
    assign full  = (q.cnt == LW'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/wbf_host_port.sv
module wbf_host_port
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr0,
    input  logic          wr,
    input  logic          rd,
    input  logic          word,
    input  logic [15:0]   wdata,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  byte_t         rx_h0,
    input  byte_t         rx_h1,
    output bcnt_t         tx_push_cnt,
    output byte_t         tx_b0,
    output byte_t         tx_b1,
    output bcnt_t         rx_pop_cnt,
    output logic [15:0]   rdata,
    output logic          ovf,
    output logic          unf,
    output logic          err
);
    typedef struct packed {
        logic [15:0] rdata;
        logic        ovf;
        logic        unf;
        logic        err;
    } hp_t;

    hp_t           d, q;
    acc_e          wr_k, rd_k;
    bcnt_t         need;
    logic [LW-1:0] tx_free;

    function automatic acc_e classify(input logic stb, input logic wd, input logic a0);
        if (!stb) return ACC_NONE;
        if (wd)   return ACC_WORD;
        if (a0)   return ACC_BAD;
        return ACC_BYTE;
    endfunction

    always_comb begin
        d           = q;
        d.ovf       = 1'b0;
        d.unf       = 1'b0;
        wr_k        = classify(wr, word, addr0);
        rd_k        = classify(rd, word, addr0);
        need        = word ? 2'd2 : 2'd1;
        tx_free     = LW'(DEPTH) - tx_level;
        tx_push_cnt = 2'd0;
        rx_pop_cnt  = 2'd0;
        tx_b0       = word ? wdata[15:8] : wdata[7:0];
        tx_b1       = wdata[7:0];

        if (wr_k == ACC_BYTE || wr_k == ACC_WORD) begin
            if (tx_free >= LW'(need)) tx_push_cnt = need;
            else                      d.ovf = 1'b1;
        end

        if (rd_k == ACC_BYTE || rd_k == ACC_WORD) begin
            if (rx_level >= LW'(need)) begin
                rx_pop_cnt = need;
                d.rdata    = word ? {rx_h0, rx_h1} : {8'h00, rx_h0};
            end else begin
                d.unf   = 1'b1;
                d.rdata = 16'h0000;
            end
        end

        d.err = (wr_k == ACC_BAD) || (rd_k == ACC_BAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.rdata;
    assign ovf   = q.ovf;
    assign unf   = q.unf;
    assign err   = q.err;
endmodule

// File: rtl/wbf_top.sv
module wbf_top
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_addr0,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_word,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data,
    output logic          tx_full,
    output logic          tx_empty,
    output logic [LW-1:0] tx_level,
    output logic          rx_full,
    output logic          rx_empty,
    output logic [LW-1:0] rx_level,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          acc_err
);
    bcnt_t tx_push_cnt, rx_pop_cnt;
    byte_t tx_b0, tx_b1, rx_h0, rx_h1, tx_peek_unused;
    logic  tx_take, rx_take;

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;
    assign tx_take  = tx_valid && tx_ready;
    assign rx_take  = rx_valid && rx_ready;

    wbf_host_port #(.DEPTH(DEPTH), .LW(LW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .addr0(host_addr0), .wr(host_wr), .rd(host_rd), .word(host_word),
        .wdata(host_wdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .rx_h0(rx_h0), .rx_h1(rx_h1),
        .tx_push_cnt(tx_push_cnt), .tx_b0(tx_b0), .tx_b1(tx_b1),
        .rx_pop_cnt(rx_pop_cnt),
        .rdata(host_rdata), .ovf(ovf_flag), .unf(unf_flag), .err(acc_err)
    );

    wbf_byte_queue #(.DEPTH(DEPTH), .LW(LW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_cnt(tx_push_cnt), .push_b0(tx_b0), .push_b1(tx_b1),
        .pop_cnt({1'b0, tx_take}),
        .head0(tx_data), .head1(tx_peek_unused),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    wbf_byte_queue #(.DEPTH(DEPTH), .LW(LW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_cnt({1'b0, rx_take}), .push_b0(rx_data), .push_b1(8'h00),
        .pop_cnt(rx_pop_cnt),
        .head0(rx_h0), .head1(rx_h1),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/wbf_checker.sv
module wbf_checker #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_addr0,
    input logic          host_wr,
    input logic          host_rd,
    input logic          host_word,
    input logic [15:0]   host_rdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_full,
    input logic          tx_empty,
    input logic [LW-1:0] tx_level,
    input logic          rx_full,
    input logic [LW-1:0] rx_level,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic          acc_err
);
    // R7
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    // R7
    byte_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_word && !host_addr0 && !tx_full && !(tx_valid && tx_ready))
        |=> (tx_level == $past(tx_level) + 1'b1));

    // R8
    word_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_word && (tx_level > LW'(DEPTH - 2)) && !(tx_valid && tx_ready))
        |=> (ovf_flag && $stable(tx_level)));

    // R9
    word_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_word && (rx_level < LW'(2)) && !(rx_valid && rx_ready))
        |=> (unf_flag && (host_rdata == 16'h0000) && $stable(rx_level)));

    // R10
    odd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_word && host_addr0 && !(tx_valid && tx_ready))
        |=> (acc_err && $stable(tx_level)));

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_ready);

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !tx_valid);
endmodule

bind wbf_top wbf_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_addr0(host_addr0), .host_wr(host_wr), .host_rd(host_rd),
    .host_word(host_word), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_full(rx_full), .rx_level(rx_level),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .acc_err(acc_err)
);

// File: tb/wbf_top_test.sv
`timescale 1ns/1ps
module wbf_top_test;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_addr0 = 1'b0, host_wr = 1'b0, host_rd = 1'b0, host_word = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          tx_valid, rx_ready;
    logic          tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]    tx_data;
    logic [7:0]    rx_data = '0;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [LW-1:0] tx_level, rx_level;
    logic          ovf_flag, unf_flag, acc_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0]  txm[$];
    logic [7:0]  rxm[$];
    logic [15:0] exp_rdata = 16'h0000;

    always #2.5 clk = ~clk;

    wbf_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr0(host_addr0), .host_wr(host_wr), .host_rd(host_rd),
        .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .acc_err(acc_err)
    );

    task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus with the expected result built from the bench queues.
    task automatic step(input logic wr, input logic rd, input logic word, input logic a0,
                        input logic [15:0] wd, input logic pop, input logic push,
                        input logic [7:0] pb);
        int  txl, rxl, need;
        bit  bad, e_ovf, e_unf, e_err;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_word = word; host_addr0 = a0;
        host_wdata = wd; tx_ready = pop; rx_valid = push; rx_data = pb;
        #1;
        txl = txm.size();
        rxl = rxm.size();
        ceq("R5 tx_valid", 32'(tx_valid), 32'(txl > 0));
        if (txl > 0) ceq("R5 tx_data", 32'(tx_data), 32'(txm[0]));
        ceq("R6 rx_ready", 32'(rx_ready), 32'(rxl < DEPTH));

        bad   = !word && a0;
        need  = word ? 2 : 1;
        e_err = (wr || rd) && bad;
        e_ovf = 0;
        e_unf = 0;
        if (pop && txl > 0) void'(txm.pop_front());
        if (wr && !bad) begin
            if (need > DEPTH - txl) e_ovf = 1;
            else if (word) begin txm.push_back(wd[15:8]); txm.push_back(wd[7:0]); end
            else txm.push_back(wd[7:0]);
        end
        if (rd && !bad) begin
            if (need > rxl) begin
                e_unf = 1;
                exp_rdata = 16'h0000;
            end else if (word) begin
                exp_rdata[15:8] = rxm.pop_front();
                exp_rdata[7:0]  = rxm.pop_front();
            end else begin
                exp_rdata = {8'h00, rxm.pop_front()};
            end
        end
        if (push && rxl < DEPTH) rxm.push_back(pb);

        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; tx_ready = 0; rx_valid = 0;
        ceq("R3 host_rdata", 32'(host_rdata), 32'(exp_rdata));
        ceq("R8 ovf_flag", 32'(ovf_flag), 32'(e_ovf));
        ceq("R9 unf_flag", 32'(unf_flag), 32'(e_unf));
        ceq("R10 acc_err", 32'(acc_err), 32'(e_err));
        ceq("R7 tx_level", 32'(tx_level), 32'(txm.size()));
        ceq("R7 rx_level", 32'(rx_level), 32'(rxm.size()));
        ceq("R7 tx_full", 32'(tx_full), 32'(txm.size() == DEPTH));
        ceq("R7 tx_empty", 32'(tx_empty), 32'(txm.size() == 0));
        ceq("R7 rx_full", 32'(rx_full), 32'(rxm.size() == DEPTH));
        ceq("R7 rx_empty", 32'(rx_empty), 32'(rxm.size() == 0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0]  exp_tx[6];
        logic [15:0] exp_rd[4];
        logic        rd_word[4];
        logic [15:0] held;
        exp_tx = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB};
        exp_rd = '{16'h0001, 16'h2345, 16'h0067, 16'h89AB};
        rd_word = '{1'b0, 1'b1, 1'b0, 1'b1};
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        ceq("R1 tx_level", 32'(tx_level), 0);
        ceq("R1 rx_level", 32'(rx_level), 0);
        ceq("R1 tx_valid", 32'(tx_valid), 0);
        ceq("R1 rx_ready", 32'(rx_ready), 1);
        ceq("R1 tx_empty", 32'(tx_empty), 1);
        ceq("R1 rx_empty", 32'(rx_empty), 1);
        ceq("R1 flags", 32'({ovf_flag, unf_flag, acc_err}), 0);
        ceq("R1 host_rdata", 32'(host_rdata), 0);

        // R2 example write sequence, drained on the card side
        step(1, 0, 1, 0, 16'h0123, 0, 0, 8'h00);
        step(1, 0, 0, 0, 16'hFF45, 0, 0, 8'h00);
        step(1, 0, 1, 0, 16'h6789, 0, 0, 8'h00);
        step(1, 0, 0, 0, 16'h00AB, 0, 0, 8'h00);
        ceq("R2 tx_level", 32'(tx_level), 6);
        for (int i = 0; i < 6; i++) begin
            ceq("R2 byte order", 32'(tx_data), 32'(exp_tx[i]));
            step(0, 0, 0, 0, 16'h0, 1, 0, 8'h00);
        end

        // R3 example read sequence after the card delivers the bytes
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 16'h0, 0, 1, exp_tx[i]);
        for (int i = 0; i < 4; i++) begin
            step(0, 1, rd_word[i], 0, 16'h0, 0, 0, 8'h00);
            ceq("R3 example read", 32'(host_rdata), 32'(exp_rd[i]));
        end

        // R8 fill outbound to DEPTH-1, then word and byte overflow
        for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 0, 16'($urandom), 0, 0, 8'h00);
        step(1, 0, 1, 0, 16'hBEEF, 0, 0, 8'h00);
        ceq("R8 word rejected", 32'(ovf_flag), 1);
        step(1, 0, 0, 0, 16'h0055, 0, 0, 8'h00);
        ceq("R7 full", 32'(tx_full), 1);
        step(1, 0, 0, 0, 16'h0066, 0, 0, 8'h00);
        ceq("R8 byte rejected", 32'(ovf_flag), 1);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 16'h0, 1, 0, 8'h00);

        // R9 underflow on empty and on a single stored byte
        step(0, 1, 1, 0, 16'h0, 0, 0, 8'h00);
        ceq("R9 empty word read", 32'(unf_flag), 1);
        step(0, 0, 0, 0, 16'h0, 0, 1, 8'h5A);
        step(0, 1, 1, 0, 16'h0, 0, 0, 8'h00);
        ceq("R9 rdata zero", 32'(host_rdata), 0);
        step(0, 1, 0, 0, 16'h0, 0, 0, 8'h00);
        ceq("R9 byte still there", 32'(host_rdata), 32'h005A);

        // R10 odd-address byte accesses are ignored
        step(0, 0, 0, 0, 16'h0, 0, 1, 8'hC3);
        held = host_rdata;
        step(0, 1, 0, 1, 16'h0, 0, 0, 8'h00);
        ceq("R10 rdata held", 32'(host_rdata), 32'(held));
        ceq("R10 rx untouched", 32'(rx_level), 1);
        step(1, 0, 0, 1, 16'h0077, 0, 0, 8'h00);
        ceq("R10 tx untouched", 32'(tx_level), 0);
        step(1, 0, 1, 1, 16'hA1B2, 0, 0, 8'h00);
        ceq("R10 word ignores addr0", 32'(tx_level), 2);

        // R4 random mixed traffic in phases biased toward fill and drain
        for (int ph = 0; ph < 4; ph++) begin
            int pw, pr, pp, pv;
            pw = (ph % 2 == 0) ? 70 : 25;
            pp = (ph % 2 == 0) ? 25 : 70;
            pv = (ph % 2 == 0) ? 70 : 25;
            pr = (ph % 2 == 0) ? 25 : 70;
            for (int n = 0; n < 600; n++) begin
                step(($urandom % 100) < pw, ($urandom % 100) < pr, $urandom % 2,
                     ($urandom % 8) == 0, 16'($urandom),
                     ($urandom % 100) < pp, ($urandom % 100) < pv, 8'($urandom));
            end
        end
        ceq("R4 final tx_level", 32'(tx_level), 32'(txm.size()));
        finish_run();
    end
endmodule